// File: doc/BRIEF.md
# SONET cell payload mapper

This transmit-side block packs fixed-size user cells into the payload area of a byte-serial STS-48c frame. It emits one frame byte per clock, tagged with its row, its column and a flag for transport-overhead slots. The overhead slots carry 0x00 and are left for a downstream inserter to fill. The frame has 9 rows of 4320 columns. Columns 0 to 143 of every row are overhead. The remaining 4176 columns of each row, 37584 bytes per frame, carry cells.

Each cell on the line has three parts: a link header byte generated here, the user payload taken from a valid/ready input stream, and a parity byte that closes it. Cells are laid end to end and continue across row ends, jumping over the overhead columns. A cell is never split between two frames. When a whole cell no longer fits, the rest of the frame payload is filled with zero pad. If no user cell is waiting when a cell slot opens, the block sends an idle cell, so the line always carries a legal layout.

Top module: `sonet_cell_mapper`

## Requirements
- R1: After reset the output walks row 0..8 and column 0..4319 in raster order, one byte per clock, with `out_valid` high. `out_oh` is high for columns 0..143. While `rst` is high, `out_valid` and `in_ready` are 0.
- R2: In every frame, a cell's link header occupies row 0, column 144.
- R3: The link header of a data cell is 0x80 ORed with a 6-bit sequence number in bits 5:0. The number is 0 after reset and increases by one, modulo 64, with each data cell.
- R4: A data cell is the header, then the L input bytes in arrival order, then the parity byte. L is the total cell size minus 2. Consecutive cells occupy consecutive payload slots across row ends.
- R5: The parity byte is the bitwise XOR of the cell's L payload bytes.
- R6: `cell_sel` picks the total cell size: 0 gives 77, 1 gives 81, 2 gives 85 and 3 gives 93 bytes.
- R7: No cell crosses a frame end. Per frame there are 488, 464, 442 or 404 cells, followed by 8, 0, 14 or 12 pad bytes of 0x00.
- R8: A data cell starts only when `in_valid` and `in_sop` are both high at a header slot. Otherwise the cell is idle: header 0xC0, payload 0x00 and parity 0x00.
- R9: `cell_sel` is sampled only in the row 0, column 0 slot. A change at any other time has no effect until the next frame.
- R10: `in_ready` is high only in the payload-byte slots of a data cell. It is low in overhead, header, parity, pad and idle-cell slots.
- R11: Overhead slots carry 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_sel | input | 2 | Cell size select, sampled at frame start |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first payload byte of a cell |
| in_data | input | 8 | Input payload byte |
| in_ready | output | 1 | Input byte is taken on this clock |
| out_data | output | 8 | Frame byte |
| out_row | output | 4 | Row of the frame byte |
| out_col | output | 13 | Column of the frame byte |
| out_oh | output | 1 | Frame byte is a transport-overhead slot |
| out_valid | output | 1 | Output stream active (low in reset) |

## Verification
The assertions check the following on every cycle:
- the column steps by one;
- overhead slots are zero;
- `in_ready` never falls into an overhead slot;
- an accepted input byte appears on the next output byte;
- row 0, column 144 always holds a header.

Other behaviour depends on history, and only the bench's scenarios can show it:
- the sequence numbering;
- the parity value;
- idle-cell substitution when the source runs dry;
- the per-size cell and pad counts;
- size changes made mid-frame taking effect only at the next frame.

The bench's behavioural model tracks these slot by slot across four frames, one for each cell size.

// File: rtl/sonet_cell_mapper_pkg.sv
package sonet_cell_mapper_pkg;

  typedef enum logic [1:0] {
    CSZ_77 = 2'd0,
    CSZ_81 = 2'd1,
    CSZ_85 = 2'd2,
    CSZ_93 = 2'd3
  } cell_size_e;

  localparam int unsigned CELL_TW = 7;

  // total on-line cell length: link header + user payload + parity byte
  function automatic logic [CELL_TW-1:0] cell_total(input logic [1:0] sel);
    case (cell_size_e'(sel))
      CSZ_77:  return 7'd77;
      CSZ_81:  return 7'd81;
      CSZ_85:  return 7'd85;
      default: return 7'd93;
    endcase
  endfunction

endpackage

// File: rtl/cmap_frame_pos.sv
module cmap_frame_pos #(
  parameter int ROWS     = 9,
  parameter int OH_COLS  = 144,
  parameter int PAY_COLS = 4176,
  localparam int COLS    = OH_COLS + PAY_COLS,
  localparam int RW      = $clog2(ROWS),
  localparam int CW      = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          oh,
  output logic          sof
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
    end else if (col == COL_LAST) begin
      col <= '0;
      row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  assign oh  = (col < CW'(OH_COLS));
  assign sof = (row == '0) && (col == '0);

endmodule

// File: rtl/cmap_cell_engine.sv
module cmap_cell_engine
  import sonet_cell_mapper_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PAY_BYTES = 37584,
  localparam int PW       = $clog2(PAY_BYTES + 1),
  localparam int SEQW     = DW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sof,
  input  logic          oh,
  input  logic [1:0]    cell_sel,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [DW-1:0] byte_nxt
);

  logic [CELL_TW-1:0] cur_total;
  logic [CELL_TW-1:0] cpos;
  logic [PW-1:0]      pay_left;
  logic               is_data;
  logic [DW-1:0]      bip;
  logic [SEQW-1:0]    seq;

  logic [CELL_TW-1:0] last_pl;
  logic               start, start_data, in_pay, in_bip;
  logic [DW-1:0]      hdr, pay_byte;

  assign last_pl    = cur_total - 7'd2;
  // a new cell may open only when the whole cell still fits in this frame
  assign start      = !oh && (cpos == '0) && (pay_left >= PW'(cur_total));
  assign start_data = start && in_valid && in_sop;
  assign in_pay     = !oh && (cpos != '0) && (cpos <= last_pl);
  assign in_bip     = !oh && (cpos > last_pl);
  assign pay_byte   = is_data ? in_data : '0;
  assign hdr        = start_data ? {1'b1, 1'b0, seq} : {1'b1, 1'b1, {SEQW{1'b0}}};
  assign in_ready   = !rst && in_pay && is_data;

  always_comb begin
    if (start)       byte_nxt = hdr;
    else if (in_pay) byte_nxt = pay_byte;
    else if (in_bip) byte_nxt = bip;
    else             byte_nxt = '0;   // overhead and pad slots
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_total <= cell_total(cell_sel);
      pay_left  <= PW'(PAY_BYTES);
      cpos      <= '0;
      is_data   <= 1'b0;
      bip       <= '0;
      seq       <= '0;
    end else if (sof) begin
      cur_total <= cell_total(cell_sel);
      pay_left  <= PW'(PAY_BYTES);
      cpos      <= '0;
    end else if (!oh) begin
      pay_left <= pay_left - 1'b1;
      if (start) begin
        cpos    <= 7'd1;
        is_data <= start_data;
        bip     <= '0;
        if (start_data) seq <= seq + 1'b1;
      end else if (in_pay) begin
        cpos <= cpos + 1'b1;
        bip  <= bip ^ pay_byte;
      end else if (in_bip) begin
        cpos <= '0;
      end
    end
  end

endmodule

// File: rtl/cmap_out_stage.sv
module cmap_out_stage #(
  parameter int DW = 8,
  parameter int RW = 4,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] byte_in,
  input  logic [RW-1:0] row_in,
  input  logic [CW-1:0] col_in,
  input  logic          oh_in,
  output logic [DW-1:0] out_data,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          out_oh,
  output logic          out_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_oh    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= byte_in;
      out_row   <= row_in;
      out_col   <= col_in;
      out_oh    <= oh_in;
      out_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/sonet_cell_mapper.sv
module sonet_cell_mapper
  import sonet_cell_mapper_pkg::*;
#(
  parameter int ROWS     = 9,
  parameter int OH_COLS  = 144,
  parameter int PAY_COLS = 4176,
  parameter int DW       = 8,
  localparam int COLS      = OH_COLS + PAY_COLS,
  localparam int RW        = $clog2(ROWS),
  localparam int CW        = $clog2(COLS),
  localparam int PAY_BYTES = ROWS * PAY_COLS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cell_sel,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          out_oh,
  output logic          out_valid
);

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          oh, sof;
  logic [DW-1:0] byte_nxt;

  cmap_frame_pos #(
    .ROWS(ROWS), .OH_COLS(OH_COLS), .PAY_COLS(PAY_COLS)
  ) u_pos (
    .clk(clk), .rst(rst), .row(row), .col(col), .oh(oh), .sof(sof)
  );

  cmap_cell_engine #(
    .DW(DW), .PAY_BYTES(PAY_BYTES)
  ) u_eng (
    .clk(clk), .rst(rst), .sof(sof), .oh(oh), .cell_sel(cell_sel),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .in_ready(in_ready), .byte_nxt(byte_nxt)
  );

  cmap_out_stage #(
    .DW(DW), .RW(RW), .CW(CW)
  ) u_out (
    .clk(clk), .rst(rst), .byte_in(byte_nxt), .row_in(row), .col_in(col),
    .oh_in(oh), .out_data(out_data), .out_row(out_row), .out_col(out_col),
    .out_oh(out_oh), .out_valid(out_valid)
  );

endmodule

// File: rtl/sonet_cell_mapper_chk.sv
module sonet_cell_mapper_chk #(
  parameter int OH_COLS = 144,
  parameter int DW      = 8,
  parameter int RW      = 4,
  parameter int CW      = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic [DW-1:0] out_data,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic          out_oh,
  input logic          out_valid
);

  // R1: consecutive output bytes advance the column by one unless it wraps to 0
  assert_column_step_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && out_col != '0) |-> (out_col == $past(out_col) + 1'b1));

  // R2: the first payload slot of each frame holds a header (valid bit set)
  assert_frame_first_header_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_row == '0 && out_col == CW'(OH_COLS)) |-> out_data[DW-1]);

  // R4: an accepted input byte is the next byte on the line
  assert_payload_passthrough_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (out_data == $past(in_data)));

  // R10: the input is never taken in an overhead slot
  assert_ready_not_overhead_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (out_valid && !out_oh));

  // R11: overhead slots are zero
  assert_overhead_zero_R11: assert property (@(posedge clk) disable iff (rst)
    out_oh |-> (out_data == '0));

endmodule

bind sonet_cell_mapper sonet_cell_mapper_chk #(
  .OH_COLS(OH_COLS), .DW(DW), .RW(RW), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_data(out_data), .out_row(out_row),
  .out_col(out_col), .out_oh(out_oh), .out_valid(out_valid)
);

// File: tb/sonet_cell_mapper_test.sv
module sonet_cell_mapper_test;
  localparam int ROWS = 9, OHC = 144, PAYC = 4176;
  localparam int COLS = OHC + PAYC, FB = ROWS * COLS, PB = ROWS * PAYC;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cell_sel = 2'd0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, out_oh, out_valid;
  logic [7:0] out_data;
  logic [3:0] out_row;
  logic [12:0] out_col;

  sonet_cell_mapper uut (
    .clk(clk), .rst(rst), .cell_sel(cell_sel), .in_valid(in_valid),
    .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
    .out_data(out_data), .out_row(out_row), .out_col(out_col),
    .out_oh(out_oh), .out_valid(out_valid)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  byte unsigned src_q[$];
  bit sop_q[$];
  byte unsigned exp_q[$];
  int sel_frame = 0, seq = 0, bip = 0, hdrs = 0, paycnt = 0;
  bit cell_data = 0;
  logic [7:0] lfsr = 8'h5A;
  int size_order[4] = '{0, 3, 2, 1};

  function automatic int tot(input int s);
    case (s)
      0: return 77;
      1: return 81;
      2: return 85;
      default: return 93;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d slot=%0d", req, what, act, exp, n);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural model step: expected content of slot n, compared against outputs
  task automatic step();
    int p, r, c, t, l, k, ci, off, e, np, nr, nc, k2, ci2, off2;
    bit exp_rdy;
    string rq;
    p = n % FB; r = p / COLS; c = p % COLS;
    if (p == 0) begin sel_frame = int'(cell_sel); hdrs = 0; paycnt = 0; end  // R9
    t = tot(sel_frame); l = t - 2;
    e = 0; rq = "R11"; ci = 0; off = 1;
    if (c >= OHC) begin
      k = r * PAYC + (c - OHC); ci = k / t; off = k % t;
      if (ci >= PB / t) rq = "R7";
      else if (off == 0) begin
        cell_data = in_valid && in_sop;
        if (cell_data) begin e = 128 + seq; seq = (seq + 1) % 64; rq = "R3"; end
        else begin e = 8'hC0; rq = "R8"; end
        bip = 0;
      end else if (off <= l) begin
        if (cell_data && exp_q.size() > 0) e = int'(exp_q.pop_front());
        rq = cell_data ? "R4" : "R8";
        bip = bip ^ e;
      end else begin
        e = bip; rq = cell_data ? "R5" : "R8";
      end
    end
    check(out_valid && int'(out_row) == r && int'(out_col) == c && out_oh == (c < OHC),
          "R1", "position", int'(out_col), c);
    check(int'(out_data) == e, rq, "byte", int'(out_data), e);
    if (!out_oh) paycnt++;
    if (c >= OHC && off == 0 && ci < PB / t && out_data[7]) hdrs++;
    if (p == OHC) check(out_data[7] == 1'b1, "R2", "first header", int'(out_data), 128);
    if (p == FB - 1) begin
      check(hdrs == PB / t, "R6 R7", "cells per frame", hdrs, PB / t);
      check(paycnt == PB, "R1", "payload slots per frame", paycnt, PB);
    end
    // expected in_ready for the next slot
    np = (n + 1) % FB; nr = np / COLS; nc = np % COLS; exp_rdy = 0;
    if (nc >= OHC) begin
      k2 = nr * PAYC + (nc - OHC); ci2 = k2 / t; off2 = k2 % t;
      if (ci2 < PB / t && off2 >= 1 && off2 <= l) exp_rdy = cell_data;
    end
    check(in_ready == exp_rdy, "R10", "in_ready", int'(in_ready), int'(exp_rdy));
    n++;
  endtask

  task automatic drive();
    int p, f, l;
    bit feed;
    p = (n - 1) % FB; f = (n - 1) / FB;
    if (f == 1 && p == 1000) cell_sel = 2'd1;              // R9: mid-frame change, ignored
    if (p == FB / 2 && f < 3) cell_sel = 2'(size_order[f + 1]);
    feed = (p < FB - 400) && !(f == 0 && p >= 5000 && p < 9000);  // R8: gap gives idle cells
    if (src_q.size() == 0 && feed) begin
      l = tot(sel_frame) - 2;
      for (int i = 0; i < l; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        src_q.push_back(lfsr);
        exp_q.push_back(lfsr);
        sop_q.push_back(i == 0);
      end
    end
    in_valid = (src_q.size() > 0);
    in_sop   = in_valid ? sop_q[0] : 1'b0;
    in_data  = in_valid ? src_q[0] : 8'd0;
    #1;
    if (in_valid && in_ready) begin
      void'(src_q.pop_front());
      void'(sop_q.pop_front());
    end
  endtask

  initial begin
    cell_sel = 2'(size_order[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b0, "R1", "reset in_ready", int'(in_ready), 0);
    rst = 1'b0;
    while (n < 4 * FB && fails <= 20) begin
      @(negedge clk);
      step();
      drive();
    end
    finish_run();
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n, 4 * FB);
      finish_run();
    end
  end

endmodule